// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block guards against runaway software. A power-of-two clock prescaler drives a down-counter, 15 bits wide by default. Software must keep writing a start register before the counter runs out. If the counter underflows, the block produces a one-cycle pulse. That pulse is either an interrupt request or a system reset request, depending on a response-mode bit. The mode bit can be raised by software but never lowered by it, so once reset escalation is armed it stays armed until a hardware reset.

The prescaler ratio follows the active bus clock source. While the main oscillator is in use, a control bit picks between a short and a long divide. While the sub-clock is in use, a fixed divide-by-two applies. A freeze input, driven by the power manager during stop, wait or bus-hold states, holds both the prescaler and the counter still. Counting picks up from the same point when freeze is released. The counter value is always visible on an output so software can see how much margin remains.

Top module: `wdog_timer`

## Requirements
- R1: After hardware reset the counter reads all ones and does not change, and neither pulse output fires, until the first write to the start register (`reg_addr` = 0).
- R2: A write to the start register loads the counter with all ones and enables counting. The counter then drops by one on every prescaler tick.
- R3: With the main source selected (`src_sub` = 0), control register bit 0 (`reg_addr` = 1) picks the divide ratio: 0 gives 2^SH_LO (16) and 1 gives 2^SH_HI (128). The time from reload to underflow is ratio × 2^CNT_W active cycles.
- R4: With the sub-clock selected (`src_sub` = 1), the ratio is 2^SH_SUB (2) whatever control bit 0 holds.
- R5: When the mode bit is 0, an underflow gives a one-cycle `irq_pulse`, reloads the counter with all ones and counting continues, so the period repeats.
- R6: When the mode bit (control register bit 1) is 1, an underflow gives a one-cycle `rst_req`, with no interrupt, and the counter stops at zero. After that, start writes are ignored until hardware reset.
- R7: Writing 0 to the mode bit has no effect once the mode bit is 1. Only hardware reset clears it, and after reset the mode is interrupt.
- R8: While `freeze` is high the prescaler and counter hold their values. After release, timing resumes from the held state, so the period grows by exactly the number of frozen cycles.
- R9: A start write does not clear the prescaler. The first tick after a mid-run restart comes when the prescaler phase already in progress completes.
- R10: `irq_pulse` and `rst_req` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = start register, 1 = control register |
| reg_wdata | input | 2 | Write data: bit 0 = long-divide select, bit 1 = reset-mode set |
| src_sub | input | 1 | 1 when the sub-clock is the bus clock source |
| freeze | input | 1 | Holds prescaler and counter while high |
| irq_pulse | output | 1 | One-cycle interrupt request on underflow |
| rst_req | output | 1 | One-cycle reset request on underflow in reset mode |
| cnt_value | output | CNT_W | Current counter value |

## Verification
The bench uses a 4-bit counter with ratios 4, 8 and 2. It follows every full period and checks the counter value on every cycle against reload minus the number of elapsed prescaler steps.

- **Ratio patterns.** Periods run under each combination of clock source and ratio bit. This separates the two main-oscillator ratios from each other and shows that the ratio bit is ignored on the sub-clock.
- **Freeze window.** A freeze placed inside a period must stretch it by exactly the frozen cycles. This distinguishes a true hold from a clear or a skip.
- **Off-phase restart.** A restart placed off the prescaler phase must produce its first step after one cycle instead of four. This shows the prescaler is not cleared by the restart.
- **Mode sequences.** Setting then clearing the mode bit, followed by a hardware reset, distinguishes the sticky escalation from an ordinary register.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Control register field positions
    localparam int unsigned CTRL_RATIO_BIT = 0;
    localparam int unsigned CTRL_ESC_BIT   = 1;
    localparam int unsigned CTRL_W         = 2;

    // Register select
    typedef enum logic {
        ADDR_START = 1'b0,
        ADDR_CTRL  = 1'b1
    } wdt_addr_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic              start_o,
    output logic              ratio_hi_o,
    output logic              esc_mode_o
);
    typedef struct packed {
        logic ratio_hi;
        logic esc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        start_o = wr_i && (addr_i == ADDR_START);
        if (wr_i && (addr_i == ADDR_CTRL)) begin
            r_d.ratio_hi = wdata_i[CTRL_RATIO_BIT];
            // mode bit can only be raised by software
            r_d.esc      = r_q.esc | wdata_i[CTRL_ESC_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ratio_hi_o = r_q.ratio_hi;
    assign esc_mode_o = r_q.esc;

    // R7
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(r_q.esc));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int unsigned SH_LO  = 4,
    parameter int unsigned SH_HI  = 7,
    parameter int unsigned SH_SUB = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic src_sub_i,
    input  logic ratio_hi_i,
    output logic tick_o
);
    localparam int unsigned PRE_W = max3(SH_LO, SH_HI, SH_SUB);
    localparam logic [PRE_W-1:0] MASK_LO  = PRE_W'((1 << SH_LO) - 1);
    localparam logic [PRE_W-1:0] MASK_HI  = PRE_W'((1 << SH_HI) - 1);
    localparam logic [PRE_W-1:0] MASK_SUB = PRE_W'((1 << SH_SUB) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t p_d, p_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        p_d = p_q;
        // ratio follows the clock source on every step
        if (src_sub_i)       mask = MASK_SUB;
        else if (ratio_hi_i) mask = MASK_HI;
        else                 mask = MASK_LO;
        tick_o = en_i && ((p_q.cnt & mask) == mask);
        if (en_i) p_d.cnt = p_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R4
    sub_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && src_sub_i) |=> !tick_o);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             esc_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             rst_o
);
    localparam logic [CNT_W-1:0] RELOAD = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             dead;
        logic             irq;
        logic             rst;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        s_d.rst = 1'b0;
        if (start_i && !s_q.dead) begin
            s_d.cnt = RELOAD;
            s_d.run = 1'b1;
        end else if (tick_i && s_q.run) begin
            if (s_q.cnt == '0) begin
                if (esc_i) begin
                    s_d.rst  = 1'b1;
                    s_d.run  = 1'b0;
                    s_d.dead = 1'b1;
                end else begin
                    s_d.irq = 1'b1;
                    s_d.cnt = RELOAD;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cnt <= RELOAD;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o = s_q.run;
    assign cnt_o = s_q.cnt;
    assign irq_o = s_q.irq;
    assign rst_o = s_q.rst;

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.irq && s_q.rst));

    // R10
    irq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |=> !s_q.irq);

    // R6
    dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dead |=> ($stable(s_q.cnt) && !s_q.irq && !s_q.rst));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W  = 15,
    parameter int unsigned SH_LO  = 4,
    parameter int unsigned SH_HI  = 7,
    parameter int unsigned SH_SUB = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [1:0]       reg_wdata,
    input  logic             src_sub,
    input  logic             freeze,
    output logic             irq_pulse,
    output logic             rst_req,
    output logic [CNT_W-1:0] cnt_value
);
    logic start;
    logic ratio_hi;
    logic esc_mode;
    logic running;
    logic tick;
    logic step_en;

    wdt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .start_o    (start),
        .ratio_hi_o (ratio_hi),
        .esc_mode_o (esc_mode)
    );

    assign step_en = running && !freeze;

    wdt_prescaler #(
        .SH_LO  (SH_LO),
        .SH_HI  (SH_HI),
        .SH_SUB (SH_SUB)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (step_en),
        .src_sub_i  (src_sub),
        .ratio_hi_i (ratio_hi),
        .tick_o     (tick)
    );

    wdt_counter #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .tick_i  (tick),
        .esc_i   (esc_mode),
        .run_o   (running),
        .cnt_o   (cnt_value),
        .irq_o   (irq_pulse),
        .rst_o   (rst_req)
    );

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !start) |=> $stable(cnt_value));

    // R6
    esc_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esc_mode |=> !irq_pulse || !$past(esc_mode));

endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
    localparam int W     = 4;
    localparam int SLO   = 2;
    localparam int SHI   = 3;
    localparam int SSUB  = 1;
    localparam int TOPV  = (1 << W) - 1;
    localparam int TICKS = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic reg_addr = 1'b0;
    logic [1:0] reg_wdata = 2'b00;
    logic src_sub = 1'b0;
    logic freeze = 1'b0;
    logic irq;
    logic rstq;
    logic [W-1:0] cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_timer #(.CNT_W(W), .SH_LO(SLO), .SH_HI(SHI), .SH_SUB(SSUB)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .src_sub   (src_sub),
        .freeze    (freeze),
        .irq_pulse (irq),
        .rst_req   (rstq),
        .cnt_value (cnt)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write(input logic a, input logic [1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // One period from an aligned point; optional write in first cycle,
    // freeze window [fs, fs+fl), optional control write at cycle 5.
    task automatic period(input bit do_wr, input logic wa, input logic [1:0] wd,
                          input logic src, input int r, input int ph, input bit exp_rst,
                          input int fs, input int fl, input bit mw, input logic [1:0] mwd,
                          input string tag);
        int n;
        int act;
        int cyc;
        bit fz;
        n = r * TICKS - ph;
        act = 0;
        cyc = 0;
        src_sub = src;
        if (do_wr) begin
            reg_wr = 1'b1; reg_addr = wa; reg_wdata = wd;
        end
        while (act < n) begin
            fz = (cyc >= fs) && (cyc < fs + fl);
            freeze = fz;
            if (mw && cyc == 5) begin
                reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = mwd;
            end
            @(negedge clk);
            reg_wr = 1'b0;
            cyc++;
            if (!fz) act++;
            if (act < n) begin
                chk(int'(cnt), TOPV - (act + ph) / r, {tag, " count"});
                chk(int'(irq), 0, {tag, " R10 no early irq"});
                chk(int'(rstq), 0, {tag, " R10 no early rst"});
            end else begin
                chk(int'(irq), exp_rst ? 0 : 1, {tag, " R10 irq at underflow"});
                chk(int'(rstq), exp_rst ? 1 : 0, {tag, " R10 rst at underflow"});
                chk(int'(cnt), exp_rst ? 0 : TOPV, {tag, " count after underflow"});
            end
        end
        freeze = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(int'(cnt), TOPV, "R1 reset count");
        chk(int'(irq), 0, "R1 reset irq");
        chk(int'(rstq), 0, "R1 reset rst");
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (cnt != TOPV[W-1:0] || irq || rstq) bad++;
        end
        chk(bad, 0, "R1 idle before start");

        write(1'b1, 2'b00);
        write(1'b0, 2'b00);
        chk(int'(cnt), TOPV, "R2 reload on start");
        period(0, 0, 2'b00, 0, 4, 0, 0, 0, 0, 0, 2'b00, "R2 R5 first");
        period(1, 1, 2'b01, 0, 8, 0, 0, 0, 0, 0, 2'b00, "R3 long ratio");
        period(1, 1, 2'b00, 0, 4, 0, 0, 0, 0, 0, 2'b00, "R3 short ratio");
        period(1, 1, 2'b01, 1, 2, 0, 0, 0, 0, 0, 2'b00, "R4 sub bit1");
        period(1, 1, 2'b00, 1, 2, 0, 0, 0, 0, 0, 2'b00, "R4 sub bit0");
        period(0, 0, 2'b00, 0, 4, 0, 0, 0, 0, 0, 2'b00, "R5 repeat");
        period(0, 0, 2'b00, 0, 4, 0, 0, 10, 7, 0, 2'b00, "R8 freeze");

        // R9: restart two cycles into a fresh prescaler phase
        @(negedge clk);
        chk(int'(cnt), TOPV, "R9 before restart a");
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 2'b00;
        @(negedge clk);
        chk(int'(cnt), TOPV, "R9 before restart b");
        reg_wr = 1'b0;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(int'(cnt), TOPV, "R9 reload on restart");
        period(0, 0, 2'b00, 0, 4, 3, 0, 0, 0, 0, 2'b00, "R9 phase kept");

        period(1, 1, 2'b10, 0, 4, 0, 1, 0, 0, 1, 2'b00, "R6 R7 escalate");
        write(1'b1, 2'b00);
        write(1'b0, 2'b00);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (cnt != 0 || irq || rstq) bad++;
        end
        chk(bad, 0, "R6 stopped after reset request");

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(int'(cnt), TOPV, "R7 count after hardware reset");
        write(1'b0, 2'b00);
        period(0, 0, 2'b00, 0, 4, 0, 0, 0, 0, 0, 2'b00, "R7 mode cleared by reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule